// File: doc/BRIEF.md
# DMA Transfer Counter with FIFO Residue Tracking

This block sits between the DMA side and the SCSI data-phase side of a storage controller. Software programs a byte count and issues a start command. The block counts bytes as they move and stores them in a 16-entry byte FIFO. When the count has been used up, it sets a terminal-count status bit. Software can read the FIFO occupancy at any time, so a driver can work out how many bytes actually reached the bus.

The count advances on the strobe that marks a completed byte for the current phase and mode. Normally that is the accepted DMA handshake. In synchronous data-in it is the bus-side acknowledge strobe instead. Any change of bus phase raises an interrupt and a phase-change status bit, even if bytes are still in the FIFO. The one exception is asynchronous data-in: there the interrupt waits until the DMA side has drained the FIFO. Bytes the target never requested can be discarded with a flush command.

Top module: `dma_residue_ctrl`

## Requirements
- R1: Writing the count low byte (address 0) and high byte (address 1) and then writing command (address 4) with bit 0 set loads the counter. A loaded value of zero means 65536. Reading addresses 0 and 1 returns the live count's low and high byte.
- R2: Outside synchronous data-in, the count drops by one for each accepted DMA handshake (`dma_ack` high while `dma_req` is high), and a bus strobe does not change it.
- R3: In synchronous data-in (`bus_phase` = 1, `sync_mode` = 1), the count drops by one for each `bus_xfer` strobe, and a DMA handshake does not change it.
- R4: Status bit 0 (terminal count) is set when the count reaches zero. It is cleared only by the next counter load; a status read does not clear it.
- R5: `dma_req` is high only while the count is nonzero and the FIFO can move a byte in the current direction: not full in data-out (`bus_phase` = 0), not empty in data-in (`bus_phase` = 1). The one exception is the drain after asynchronous data-in. A `dma_ack` while `dma_req` is low is ignored.
- R6: The FIFO holds 16 bytes and returns them in arrival order at `dma_rdata`/`bus_rdata`. Address 3 reads its occupancy (0 to 16). A write while it is full is dropped.
- R7: A change of `bus_phase` sets `irq` and status bit 1 at the next clock edge. This holds whatever the FIFO contains, including a data-out residue and a synchronous data-in residue.
- R8: When the phase leaves asynchronous data-in with bytes still in the FIFO, `dma_req` stays up until the FIFO is empty, and `irq` rises only at the edge that empties it.
- R9: Status bit 7 mirrors `irq`. Reading address 2 with `reg_rd` returns the status and then clears `irq` and bit 1.
- R10: Writing command bit 1 empties the FIFO at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on status) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_phase | input | 3 | Current bus phase (0 data-out, 1 data-in, others non-data) |
| sync_mode | input | 1 | Synchronous transfer mode |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge, one byte per cycle high |
| dma_wdata | input | 8 | Byte from DMA side (data-out) |
| dma_rdata | output | 8 | FIFO head byte toward DMA side (data-in) |
| bus_xfer | input | 1 | Bus-side acknowledge strobe, one byte per cycle high |
| bus_wdata | input | 8 | Byte from bus side (data-in) |
| bus_rdata | output | 8 | FIFO head byte toward bus side (data-out) |
| irq | output | 1 | Interrupt |

## Verification
The bench leaves a data-out residue after terminal count. A design that flushed the FIFO, or held back the interrupt until empty, would report zero leftover bytes or never interrupt. It runs synchronous data-in with DMA handshakes mixed in, which catches a counter wired to the wrong strobe. It also runs asynchronous data-in with one byte left when the phase changes; there an early interrupt or a dropped `dma_req` shows up at once. Filling the FIFO to 16 with an extra acknowledge catches overflow and a request that ignores the full flag. A zero load that must read back 0xFFFF after one byte catches a counter that treats zero as "done".

// File: rtl/drc_pkg.sv
`timescale 1ns/1ps
package drc_pkg;
    // register addresses
    localparam logic [2:0] ADDR_CNT_LO = 3'd0;
    localparam logic [2:0] ADDR_CNT_HI = 3'd1;
    localparam logic [2:0] ADDR_STATUS = 3'd2;
    localparam logic [2:0] ADDR_FLAGS  = 3'd3;
    localparam logic [2:0] ADDR_CMD    = 3'd4;

    // bus phase codes that carry data
    localparam logic [2:0] PH_DOUT = 3'd0;
    localparam logic [2:0] PH_DIN  = 3'd1;

    // bit positions
    localparam int STAT_TC    = 0;
    localparam int STAT_CHG   = 1;
    localparam int STAT_IRQ   = 7;
    localparam int CMD_LOAD   = 0;
    localparam int CMD_FLUSH  = 1;

    typedef struct packed {
        logic       vld;
        logic [2:0] phase;
        logic       drain;
        logic       irq;
        logic       chg;
    } evt_state_t;
endpackage

// File: rtl/drc_fifo.sv
`timescale 1ns/1ps
module drc_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int OW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  dout,
    output logic [OW-1:0] occ,
    output logic [OW-1:0] occ_nx,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [OW-1:0]           occ;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_push = push && (s_q.occ != OW'(DEPTH));
        do_pop  = pop && (s_q.occ != '0);
        if (flush) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.occ = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wr] = din;
                s_d.wr          = ptr_inc(s_q.wr);
            end
            if (do_pop) begin
                s_d.rd = ptr_inc(s_q.rd);
            end
            s_d.occ = s_q.occ + OW'(do_push) - OW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout   = s_q.mem[s_q.rd];
    assign occ    = s_q.occ;
    assign occ_nx = s_d.occ;
    assign full   = (s_q.occ == OW'(DEPTH));
    assign empty  = (s_q.occ == '0);
endmodule

// File: rtl/drc_counter.sv
`timescale 1ns/1ps
module drc_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt_view,
    output logic          active,
    output logic          tc
);
    typedef struct packed {
        logic [CW:0] cnt;
        logic        tc;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.cnt = (load_val == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, load_val};
            s_d.tc  = 1'b0;
        end else if (dec && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == (CW+1)'(1)) s_d.tc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_view = s_q.cnt[CW-1:0];
    assign active   = (s_q.cnt != '0);
    assign tc       = s_q.tc;
endmodule

// File: rtl/drc_events.sv
`timescale 1ns/1ps
module drc_events
    import drc_pkg::*;
#(
    parameter int OW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    bus_phase,
    input  logic          sync_mode,
    input  logic [OW-1:0] occ_nx,
    input  logic          rd_clr,
    output logic          irq,
    output logic          chg,
    output logic          drain
);
    evt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rd_clr) begin
            s_d.irq = 1'b0;
            s_d.chg = 1'b0;
        end
        if (!s_q.vld) begin
            s_d.vld   = 1'b1;
            s_d.phase = bus_phase;
        end else if (bus_phase != s_q.phase) begin
            s_d.phase = bus_phase;
            if ((s_q.phase == PH_DIN) && !sync_mode && (occ_nx != '0)) begin
                s_d.drain = 1'b1;
            end else begin
                s_d.drain = 1'b0;
                s_d.irq   = 1'b1;
                s_d.chg   = 1'b1;
            end
        end else if (s_q.drain && (occ_nx == '0)) begin
            s_d.drain = 1'b0;
            s_d.irq   = 1'b1;
            s_d.chg   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq   = s_q.irq;
    assign chg   = s_q.chg;
    assign drain = s_q.drain;
endmodule

// File: rtl/dma_residue_ctrl.sv
`timescale 1ns/1ps
module dma_residue_ctrl
    import drc_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int REG_W      = 8,
    localparam int CNT_W     = 2 * REG_W,
    localparam int OW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [2:0]       bus_phase,
    input  logic             sync_mode,
    output logic             dma_req,
    input  logic             dma_ack,
    input  logic [REG_W-1:0] dma_wdata,
    output logic [REG_W-1:0] dma_rdata,
    input  logic             bus_xfer,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq
);
    typedef struct packed {
        logic [REG_W-1:0] lo;
        logic [REG_W-1:0] hi;
    } stage_t;

    stage_t stg_d, stg_q;

    logic             cmd_load, cmd_flush, rd_clr;
    logic             drain, chg, tc, cnt_active;
    logic             fifo_full, fifo_empty;
    logic [OW-1:0]    occ, occ_nx;
    logic [CNT_W-1:0] cnt_view;
    logic [REG_W-1:0] head;
    logic             din_side, dout_side, sync_din;
    logic             dma_take, push, pop, dec;
    logic [REG_W-1:0] push_data;

    assign cmd_load  = reg_wr && (reg_addr == ADDR_CMD) && reg_wdata[CMD_LOAD];
    assign cmd_flush = reg_wr && (reg_addr == ADDR_CMD) && reg_wdata[CMD_FLUSH];
    assign rd_clr    = reg_rd && (reg_addr == ADDR_STATUS);

    // staging registers for the byte count
    always_comb begin
        stg_d = stg_q;
        if (reg_wr && (reg_addr == ADDR_CNT_LO)) stg_d.lo = reg_wdata;
        if (reg_wr && (reg_addr == ADDR_CNT_HI)) stg_d.hi = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    // direction and strobe routing
    assign din_side  = (bus_phase == PH_DIN) || drain;
    assign dout_side = (bus_phase == PH_DOUT) && !drain;
    assign sync_din  = (bus_phase == PH_DIN) && sync_mode && !drain;

    assign dma_req   = (drain && !fifo_empty) ||
                       (cnt_active && ((dout_side && !fifo_full) ||
                                       (din_side && !fifo_empty)));
    assign dma_take  = dma_ack && dma_req;
    assign push      = (dout_side && dma_take) ||
                       ((bus_phase == PH_DIN) && !drain && bus_xfer);
    assign pop       = (dout_side && bus_xfer) || (din_side && dma_take);
    assign push_data = dout_side ? dma_wdata : bus_wdata;
    assign dec       = sync_din ? bus_xfer : dma_take;

    drc_fifo #(.DEPTH(FIFO_DEPTH), .W(REG_W)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .din    (push_data),
        .pop    (pop),
        .flush  (cmd_flush),
        .dout   (head),
        .occ    (occ),
        .occ_nx (occ_nx),
        .full   (fifo_full),
        .empty  (fifo_empty)
    );

    drc_counter #(.CW(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_load),
        .load_val ({stg_q.hi, stg_q.lo}),
        .dec      (dec),
        .cnt_view (cnt_view),
        .active   (cnt_active),
        .tc       (tc)
    );

    drc_events #(.OW(OW)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_phase (bus_phase),
        .sync_mode (sync_mode),
        .occ_nx    (occ_nx),
        .rd_clr    (rd_clr),
        .irq       (irq),
        .chg       (chg),
        .drain     (drain)
    );

    // register readback
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CNT_LO: reg_rdata = cnt_view[REG_W-1:0];
            ADDR_CNT_HI: reg_rdata = cnt_view[CNT_W-1:REG_W];
            ADDR_STATUS: begin
                reg_rdata[STAT_TC]  = tc;
                reg_rdata[STAT_CHG] = chg;
                reg_rdata[STAT_IRQ] = irq;
            end
            ADDR_FLAGS:  reg_rdata = REG_W'(occ);
            default:     reg_rdata = '0;
        endcase
    end

    assign dma_rdata = head;
    assign bus_rdata = head;
endmodule

// File: rtl/drc_checker.sv
`timescale 1ns/1ps
module drc_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 16,
    localparam int OW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dma_req,
    input logic          dout_side,
    input logic          fifo_full,
    input logic          cnt_active,
    input logic          drain,
    input logic          irq,
    input logic          tc,
    input logic          cmd_load,
    input logic          cmd_flush,
    input logic [OW-1:0] occ,
    input logic [CW-1:0] cnt_view,
    input logic          sync_din,
    input logic          bus_xfer
);
    assert_occ_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(DEPTH));

    assert_req_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_side && fifo_full) |-> !dma_req);

    assert_req_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_active && !drain) |-> !dma_req);

    assert_tc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !cmd_load) |=> tc);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_load |=> ((cnt_view == $past(cnt_view)) ||
                       (cnt_view == CW'($past(cnt_view) - 1'b1))));

    assert_sync_din_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_din && !bus_xfer && !cmd_load) |=> (cnt_view == $past(cnt_view)));

    assert_no_irq_in_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !drain);

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_flush |=> (occ == '0));
endmodule

bind dma_residue_ctrl drc_checker #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_req    (dma_req),
    .dout_side  (dout_side),
    .fifo_full  (fifo_full),
    .cnt_active (cnt_active),
    .drain      (drain),
    .irq        (irq),
    .tc         (tc),
    .cmd_load   (cmd_load),
    .cmd_flush  (cmd_flush),
    .occ        (occ),
    .cnt_view   (cnt_view),
    .sync_din   (sync_din),
    .bus_xfer   (bus_xfer)
);

// File: tb/tb_dma_residue_ctrl.sv
`timescale 1ns/1ps
module tb_dma_residue_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_LO = 3'd0, A_HI = 3'd1, A_ST = 3'd2, A_FL = 3'd3, A_CMD = 3'd4;
    localparam logic [2:0] P_DOUT = 3'd0, P_DIN = 3'd1, P_MSGIN = 3'd7, P_STAT = 3'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic [2:0] bus_phase = P_MSGIN;
    logic       sync_mode = 1'b0;
    logic       dma_req, dma_ack = 1'b0;
    logic [7:0] dma_wdata = '0, dma_rdata;
    logic       bus_xfer = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_residue_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_phase(bus_phase), .sync_mode(sync_mode), .dma_req(dma_req),
        .dma_ack(dma_ack), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
        .bus_xfer(bus_xfer), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic rd_status(output logic [7:0] d);
        @(negedge clk); reg_addr = A_ST; reg_rd = 1'b1; #1; d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic dma_pulse(input logic [7:0] d);
        @(negedge clk); dma_ack = 1'b1; dma_wdata = d;
        @(negedge clk); dma_ack = 1'b0;
    endtask

    task automatic bus_pulse(input logic [7:0] d);
        @(negedge clk); bus_xfer = 1'b1; bus_wdata = d;
        @(negedge clk); bus_xfer = 1'b0;
    endtask

    task automatic set_phase(input logic [2:0] p);
        @(negedge clk); bus_phase = p;
        @(negedge clk);
    endtask

    task automatic enter_phase(input logic [2:0] p);
        logic [7:0] s;
        set_phase(p);
        rd_status(s);
    endtask

    task automatic load_count(input logic [7:0] lo, input logic [7:0] hi);
        wr_reg(A_LO, lo);
        wr_reg(A_HI, hi);
        wr_reg(A_CMD, 8'h01);
    endtask

    task automatic test_reset;
        logic [7:0] d;
        peek(A_ST, d); check("R9 reset status", d, 0);
        peek(A_FL, d); check("R6 reset flags", d, 0);
        check("R5 reset dma_req", dma_req, 0);
        check("R7 reset irq", irq, 0);
    endtask

    task automatic test_dout_residue;
        logic [7:0] d;
        sync_mode = 1'b0;
        enter_phase(P_DOUT);
        load_count(8'd3, 8'd0);
        peek(A_ST, d); check("R4 tc clear after load", d, 0);
        check("R5 req after load", dma_req, 1);
        dma_pulse(8'h11); dma_pulse(8'h22); dma_pulse(8'h33);
        peek(A_LO, d); check("R2 count consumed", d, 0);
        peek(A_ST, d); check("R4 tc set", d, 8'h01);
        check("R5 req drops at zero", dma_req, 0);
        peek(A_FL, d); check("R6 flags three", d, 3);
        check("R6 head order", bus_rdata, 8'h11);
        bus_pulse(8'h00);
        peek(A_FL, d); check("R6 flags after bus pop", d, 2);
        check("R6 next head", bus_rdata, 8'h22);
        set_phase(P_MSGIN);
        check("R7 irq on phase change with residue", irq, 1);
        rd_status(d); check("R9 status before clear", d, 8'h83);
        peek(A_FL, d); check("R7 residue kept", d, 2);
        check("R9 irq cleared by read", irq, 0);
        peek(A_ST, d); check("R4 tc survives status read", d, 8'h01);
        wr_reg(A_CMD, 8'h02);
        peek(A_FL, d); check("R10 flush empties", d, 0);
    endtask

    task automatic test_full;
        logic [7:0] d;
        enter_phase(P_DOUT);
        load_count(8'd20, 8'd0);
        peek(A_ST, d); check("R4 tc cleared by reload", d, 0);
        for (int i = 0; i < 16; i++) dma_pulse(8'(i + 8'h40));
        peek(A_FL, d); check("R6 flags full", d, 16);
        check("R5 req low when full", dma_req, 0);
        dma_pulse(8'hEE);
        peek(A_FL, d); check("R5 ack without req ignored flags", d, 16);
        peek(A_LO, d); check("R5 ack without req ignored count", d, 4);
        check("R6 head is first byte", bus_rdata, 8'h40);
        bus_pulse(8'h00);
        peek(A_FL, d); check("R6 flags after pop", d, 15);
        check("R5 req back after pop", dma_req, 1);
        peek(A_LO, d); check("R2 bus strobe no decrement in data-out", d, 4);
        wr_reg(A_CMD, 8'h02);
        peek(A_FL, d); check("R10 flush from full", d, 0);
    endtask

    task automatic test_zero_load;
        logic [7:0] d;
        enter_phase(P_DOUT);
        load_count(8'd0, 8'd0);
        peek(A_ST, d); check("R1 zero load not terminal", d, 0);
        check("R1 zero load requests", dma_req, 1);
        dma_pulse(8'h55);
        peek(A_LO, d); check("R1 65536 minus one low", d, 8'hFF);
        peek(A_HI, d); check("R1 65536 minus one high", d, 8'hFF);
        wr_reg(A_CMD, 8'h02);
        enter_phase(P_STAT);
        check("R5 no req in non-data phase", dma_req, 0);
        dma_pulse(8'h66);
        peek(A_LO, d); check("R5 ignored ack count", d, 8'hFF);
        peek(A_FL, d); check("R5 ignored ack flags", d, 0);
    endtask

    task automatic test_sync_din;
        logic [7:0] d;
        sync_mode = 1'b1;
        enter_phase(P_DIN);
        load_count(8'd4, 8'd0);
        bus_pulse(8'h5A); bus_pulse(8'h6B);
        peek(A_LO, d); check("R3 bus strobes count", d, 2);
        peek(A_FL, d); check("R6 sync din flags", d, 2);
        check("R6 sync din head", dma_rdata, 8'h5A);
        dma_pulse(8'h00);
        peek(A_LO, d); check("R3 dma handshake no count", d, 2);
        peek(A_FL, d); check("R6 sync din pop", d, 1);
        set_phase(P_STAT);
        check("R7 irq with sync din residue", irq, 1);
        peek(A_FL, d); check("R7 sync residue kept", d, 1);
        rd_status(d);
        wr_reg(A_CMD, 8'h02);
        sync_mode = 1'b0;
    endtask

    task automatic test_async_din;
        logic [7:0] d;
        sync_mode = 1'b0;
        enter_phase(P_DIN);
        load_count(8'd4, 8'd0);
        bus_pulse(8'hA1); bus_pulse(8'hA2);
        peek(A_LO, d); check("R2 bus strobes no count async", d, 4);
        dma_pulse(8'h00);
        peek(A_LO, d); check("R2 async dma count", d, 3);
        peek(A_FL, d); check("R6 async one left", d, 1);
        set_phase(P_MSGIN);
        check("R8 irq deferred", irq, 0);
        check("R8 req during drain", dma_req, 1);
        check("R8 drain head", dma_rdata, 8'hA2);
        dma_pulse(8'h00);
        check("R8 irq after drain", irq, 1);
        peek(A_FL, d); check("R8 fifo drained", d, 0);
        peek(A_LO, d); check("R8 drain counted", d, 2);
        rd_status(d); check("R9 status after drain", d, 8'h82);
        check("R8 req off after drain", dma_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_dout_residue();
        test_full();
        test_zero_load();
        test_sync_din();
        test_async_din();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule